// File: doc/BRIEF.md
# Message Buffer Channel and Cycle Acceptance Filter

This block gates the traffic of one dedicated message buffer in a dual-channel time-triggered bus controller. It compares the buffer's header fields with the running schedule: a two-bit channel selection, a seven-bit cycle code, a slot identifier and a direction bit. The schedule inputs are the 6-bit cycle counter, the slot counter and a flag that marks the dynamic segment. From this comparison the block decides whether the buffer transmits, and on which channels. For a receive buffer it decides whether a valid frame from channel A or channel B is written to storage.

The channel field plays two roles. On a transmit buffer it says where the frame goes. On a receive buffer it says which channels may deliver a frame. Sending or accepting on both channels is allowed only in the static segment. When a receive buffer accepts both channels, only the first valid frame in a slot is kept. The schedule logic pulses `slot_start` once at the start of every slot. A transmit decision is made on that pulse. A store decision is made on each receive-valid strobe. Every decision appears as a one-cycle registered pulse.

Top module: `mbf_accept_filter`

## Requirements
- R1: Cycle code decoding: the highest set bit of `hdr_cycle_code`, at position n (0..6), sets a repetition of 2^n, and the bits below it set the base. A cycle matches when `cur_cycle` mod 2^n equals the base. Code 0000001 matches every cycle. Code 1000101 matches only cycle 5.
- R2: A cycle code of all zeros matches no cycle, so the buffer neither transmits nor stores.
- R3: Nothing is transmitted or stored unless `cur_slot` equals `hdr_slot_id`.
- R4: Channel field 2'b10 (bit 1 = channel A, bit 0 = channel B) transmits on A only, or stores frames received on A only.
- R5: Channel field 2'b01 transmits on B only, or stores frames received on B only.
- R6: Channel field 2'b00 transmits on neither channel, and every received frame is dropped.
- R7: Channel field 2'b11 with `seg_dynamic` low transmits on both channels, or stores a valid frame arriving on A or on B.
- R8: Channel field 2'b11 with `seg_dynamic` high behaves exactly like 2'b00.
- R9: At most one store pulse is produced per slot. A second valid frame in the same slot is dropped. Valid strobes on A and B in the same cycle give one pulse. `slot_start` re-arms storing, and a strobe in the `slot_start` cycle belongs to the new slot.
- R10: After reset all outputs are low. `tx_en_a`/`tx_en_b` pulse for exactly one cycle, one cycle after the matching `slot_start`. `store` pulses for one cycle, one cycle after the accepted receive strobe.
- R11: A buffer with `hdr_is_tx` high never stores. A buffer with `hdr_is_tx` low never transmits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_chan | input | 2 | Channel selection, bit 1 = A, bit 0 = B |
| hdr_cycle_code | input | CODE_W (7) | Cycle repetition/base code |
| hdr_slot_id | input | ID_W (11) | Slot the buffer is assigned to |
| hdr_is_tx | input | 1 | 1 = transmit buffer, 0 = receive buffer |
| cur_cycle | input | CODE_W-1 (6) | Current cycle counter |
| cur_slot | input | ID_W (11) | Current slot counter |
| seg_dynamic | input | 1 | 1 while in the dynamic segment |
| slot_start | input | 1 | One-cycle pulse at each slot start |
| rx_valid_a | input | 1 | Valid frame received on channel A |
| rx_valid_b | input | 1 | Valid frame received on channel B |
| tx_en_a | output | 1 | Transmit on channel A |
| tx_en_b | output | 1 | Transmit on channel B |
| store | output | 1 | Store the received frame |

## Verification
The cycle filter is driven with codes whose highest set bit sits at positions 0, 2 and 6. Matching and non-matching cycles are checked for each, which shows that the repetition and the base are decoded separately. A zero code is also applied. Each channel field value is applied in both directions and under both segment flags, with strobes on A alone, on B alone and on both at once. This tells a wrong channel mapping apart from a missing dynamic-segment override. Back-to-back strobes within a slot, and the same strobes after a fresh `slot_start`, tell the first-frame lock apart from a lock that never re-arms.

// File: rtl/mbf_pkg.sv
// Package: shared types and helpers for the message buffer acceptance filter.
// Assumes the channel field is packed as {A, B} with A in the upper bit.
package mbf_pkg;

    // Channel selection as carried in the buffer header.
    typedef struct packed {
        logic use_a;
        logic use_b;
    } chan_sel_t;

    // Per-channel decision pair.
    typedef struct packed {
        logic on_a;
        logic on_b;
    } chan_pair_t;

    // Channel selection that remains in force once the segment is known:
    // dual-channel selection in the dynamic segment is cancelled.
    function automatic chan_sel_t effective_chan(input chan_sel_t sel, input logic dyn);
        chan_sel_t r;
        if (dyn && sel.use_a && sel.use_b) begin
            r.use_a = 1'b0;
            r.use_b = 1'b0;
        end else begin
            r = sel;
        end
        return r;
    endfunction

endpackage

// File: rtl/mbf_cycle_match.sv
// Module: mbf_cycle_match
// Decides whether the current cycle counter belongs to the cycle set
// encoded by a repetition/base code. The highest set code bit n selects
// a repetition of 2^n; the code bits below n are the base. Purely
// combinational. Assumes cycle width is CODE_W-1.
module mbf_cycle_match #(
    parameter int CODE_W = 7,
    localparam int CYC_W = CODE_W - 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CYC_W-1:0]  cycle,
    output logic              hit
);

    logic [CODE_W-1:0] lead_sel;   // one-hot: position of highest set bit
    logic [CODE_W-1:0] base_ok;    // cycle matches base for that repetition

    for (genvar g = 0; g < CODE_W; g++) begin : g_rep
        localparam logic [CYC_W-1:0] LOW_MASK = CYC_W'((64'd1 << g) - 64'd1);
        localparam logic [CODE_W-1:0] HIGH_MASK = ~CODE_W'((64'd1 << (g + 1)) - 64'd1);

        // Select this repetition when bit g is the leading one.
        always_comb begin
            lead_sel[g] = code[g] && ((code & HIGH_MASK) == '0);
        end

        // Compare the low g bits of cycle with the base bits of the code.
        always_comb begin
            base_ok[g] = ((cycle ^ code[CYC_W-1:0]) & LOW_MASK) == '0;
        end
    end

    // Combine: a zero code has no leading bit and therefore never hits.
    always_comb begin
        hit = |(lead_sel & base_ok);
    end

endmodule

// File: rtl/mbf_chan_gate.sv
// Module: mbf_chan_gate
// Turns the header channel field, the segment, the direction and the
// schedule match into next-cycle transmit enables and a receive-accept
// request. Purely combinational. Assumes slot_start is a single-cycle
// pulse and the receive strobes are already validated frames.
module mbf_chan_gate
    import mbf_pkg::*;
(
    input  chan_sel_t  chan,
    input  logic       seg_dynamic,
    input  logic       is_tx,
    input  logic       sched_hit,
    input  logic       slot_start,
    input  logic       rx_valid_a,
    input  logic       rx_valid_b,
    output chan_pair_t tx_next,
    output logic       rx_accept
);

    chan_sel_t eff;
    logic      tx_fire;
    logic      rx_open;

    // Resolve the dynamic-segment override of dual selection.
    always_comb begin
        eff = effective_chan(chan, seg_dynamic);
    end

    // Transmit is decided once per slot, on the slot start pulse.
    always_comb begin
        tx_fire = is_tx && sched_hit && slot_start;
    end

    // Reception is open for receive buffers whose schedule matches.
    always_comb begin
        rx_open = !is_tx && sched_hit;
    end

    // Per-channel transmit enables for the following cycle.
    always_comb begin
        tx_next.on_a = tx_fire && eff.use_a;
        tx_next.on_b = tx_fire && eff.use_b;
    end

    // Any valid frame on an enabled channel requests a store.
    always_comb begin
        rx_accept = rx_open && ((rx_valid_a && eff.use_a) || (rx_valid_b && eff.use_b));
    end

endmodule

// File: rtl/mbf_first_frame.sv
// Module: mbf_first_frame
// Keeps the "already stored in this slot" lock and issues the registered
// store pulse. A slot start re-arms the lock; a request in the same cycle
// as slot_start is treated as part of the new slot. Synchronous
// active-low reset.
module mbf_first_frame (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_start,
    input  logic request,
    output logic store_q
);

    logic taken_q;
    logic taken_now;
    logic grant;

    // Lock state as seen by this cycle's request.
    always_comb begin
        taken_now = slot_start ? 1'b0 : taken_q;
    end

    // Grant only the first request since the last slot start.
    always_comb begin
        grant = request && !taken_now;
    end

    // Update the lock and register the store pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q <= 1'b0;
            store_q <= 1'b0;
        end else begin
            taken_q <= taken_now || grant;
            store_q <= grant;
        end
    end

endmodule

// File: rtl/mbf_accept_filter.sv
// Module: mbf_accept_filter (top)
// Acceptance filter for one dedicated message buffer: combines cycle-set
// membership, slot identity, channel selection, segment and direction
// into registered per-channel transmit pulses and a store pulse.
// Assumes slot_start pulses once per slot and that cur_slot/cur_cycle
// are stable around it. Synchronous active-low reset.
module mbf_accept_filter #(
    parameter int ID_W   = 11,
    parameter int CODE_W = 7,
    localparam int CYC_W = CODE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hdr_chan,
    input  logic [CODE_W-1:0] hdr_cycle_code,
    input  logic [ID_W-1:0]   hdr_slot_id,
    input  logic              hdr_is_tx,
    input  logic [CYC_W-1:0]  cur_cycle,
    input  logic [ID_W-1:0]   cur_slot,
    input  logic              seg_dynamic,
    input  logic              slot_start,
    input  logic              rx_valid_a,
    input  logic              rx_valid_b,
    output logic              tx_en_a,
    output logic              tx_en_b,
    output logic              store
);
    import mbf_pkg::*;

    logic       cycle_hit;
    logic       slot_hit;
    logic       sched_hit;
    chan_pair_t tx_next;
    chan_pair_t tx_q;
    logic       rx_accept;

    // Cycle-set membership of the current cycle.
    mbf_cycle_match #(.CODE_W(CODE_W)) u_cycle (
        .code  (hdr_cycle_code),
        .cycle (cur_cycle),
        .hit   (cycle_hit)
    );

    // Slot identity and overall schedule match.
    always_comb begin
        slot_hit  = (cur_slot == hdr_slot_id);
        sched_hit = slot_hit && cycle_hit;
    end

    // Channel, segment and direction gating.
    mbf_chan_gate u_gate (
        .chan        (chan_sel_t'(hdr_chan)),
        .seg_dynamic (seg_dynamic),
        .is_tx       (hdr_is_tx),
        .sched_hit   (sched_hit),
        .slot_start  (slot_start),
        .rx_valid_a  (rx_valid_a),
        .rx_valid_b  (rx_valid_b),
        .tx_next     (tx_next),
        .rx_accept   (rx_accept)
    );

    // First-valid-frame lock and store pulse.
    mbf_first_frame u_first (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .request    (rx_accept),
        .store_q    (store)
    );

    // Register the transmit enables as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_next;
        end
    end

    assign tx_en_a = tx_q.on_a;
    assign tx_en_b = tx_q.on_b;

endmodule

// File: rtl/mbf_accept_filter_chk.sv
// Module: mbf_accept_filter_chk
// Assertion checker bound to mbf_accept_filter. Observes ports only.
module mbf_accept_filter_chk #(
    parameter int ID_W   = 11,
    parameter int CODE_W = 7,
    localparam int CYC_W = CODE_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        hdr_chan,
    input logic [CODE_W-1:0] hdr_cycle_code,
    input logic [ID_W-1:0]   hdr_slot_id,
    input logic              hdr_is_tx,
    input logic [CYC_W-1:0]  cur_cycle,
    input logic [ID_W-1:0]   cur_slot,
    input logic              seg_dynamic,
    input logic              slot_start,
    input logic              rx_valid_a,
    input logic              rx_valid_b,
    input logic              tx_en_a,
    input logic              tx_en_b,
    input logic              store
);

    logic ss_q;
    logic stored_q;

    // Track whether a store occurred since the last slot start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q     <= 1'b0;
            stored_q <= 1'b0;
        end else begin
            ss_q     <= slot_start;
            stored_q <= store ? 1'b1 : (ss_q ? 1'b0 : stored_q);
        end
    end

    AST_ONE_STORE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> (!stored_q || ss_q)); // R9
    AST_TX_AT_OWN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_a || tx_en_b) |-> $past(slot_start && cur_slot == hdr_slot_id)); // R3
    AST_ZERO_CODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_a || tx_en_b || store) |-> $past(hdr_cycle_code != '0)); // R2
    AST_DYN_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_a && tx_en_b) |-> $past(!seg_dynamic)); // R8
    AST_STORE_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> $past(rx_valid_a || rx_valid_b)); // R10
    AST_RX_BUF_ONLY_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        store |-> $past(!hdr_is_tx)); // R11
    AST_TX_BUF_ONLY_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en_a || tx_en_b) |-> $past(hdr_is_tx)); // R11
    AST_CHAN_A_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_a |-> $past(hdr_chan[1])); // R4
    AST_CHAN_B_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_b |-> $past(hdr_chan[0])); // R5

endmodule

bind mbf_accept_filter mbf_accept_filter_chk #(.ID_W(ID_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/mbf_accept_filter_test.sv
`timescale 1ns/1ps
module mbf_accept_filter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  hdr_chan;
    logic [6:0]  hdr_cycle_code;
    logic [10:0] hdr_slot_id;
    logic        hdr_is_tx;
    logic [5:0]  cur_cycle;
    logic [10:0] cur_slot;
    logic        seg_dynamic;
    logic        slot_start;
    logic        rx_valid_a;
    logic        rx_valid_b;
    logic        tx_en_a;
    logic        tx_en_b;
    logic        store;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mbf_accept_filter uut (.*);

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {tx_a,tx_b,store} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] ch, input logic [6:0] code, input logic [5:0] cyc,
                         input logic tx, input logic dyn, input logic slot_eq);
        hdr_chan       = ch;
        hdr_cycle_code = code;
        cur_cycle      = cyc;
        hdr_is_tx      = tx;
        seg_dynamic    = dyn;
        hdr_slot_id    = 11'd17;
        cur_slot       = slot_eq ? 11'd17 : 11'd18;
    endtask

    // Pulse slot_start; check transmit pulse next cycle and its end after.
    task automatic tx_slot(input string req, input logic ea, input logic eb);
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
        check(req, {tx_en_a, tx_en_b, store}, {ea, eb, 1'b0});
        @(negedge clk);
        check("R10", {tx_en_a, tx_en_b, store}, 3'b000);
    endtask

    // Start a new slot without receive strobes.
    task automatic new_slot();
        slot_start = 1'b1;
        @(negedge clk);
        slot_start = 1'b0;
    endtask

    // Drive receive strobes for one cycle and check the store pulse.
    task automatic rx(input string req, input logic a, input logic b, input logic es);
        rx_valid_a = a;
        rx_valid_b = b;
        @(negedge clk);
        rx_valid_a = 1'b0;
        rx_valid_b = 1'b0;
        check(req, {tx_en_a, tx_en_b, store}, {2'b00, es});
    endtask

    task automatic t_reset();
        check("R10 reset", {tx_en_a, tx_en_b, store}, 3'b000);
    endtask

    task automatic t_cycle_code();
        setup(2'b10, 7'b0000101, 6'd9, 1'b1, 1'b0, 1'b1); tx_slot("R1 rep4 base1 cyc9", 1'b1, 1'b0);
        setup(2'b10, 7'b0000101, 6'd2, 1'b1, 1'b0, 1'b1); tx_slot("R1 rep4 base1 cyc2", 1'b0, 1'b0);
        setup(2'b10, 7'b1000101, 6'd5, 1'b1, 1'b0, 1'b1); tx_slot("R1 rep64 cyc5", 1'b1, 1'b0);
        setup(2'b10, 7'b1000101, 6'd37, 1'b1, 1'b0, 1'b1); tx_slot("R1 rep64 cyc37", 1'b0, 1'b0);
        setup(2'b10, 7'b0000001, 6'd63, 1'b1, 1'b0, 1'b1); tx_slot("R1 every cycle", 1'b1, 1'b0);
    endtask

    task automatic t_zero_and_slot();
        setup(2'b11, 7'b0000000, 6'd0, 1'b1, 1'b0, 1'b1); tx_slot("R2 zero code tx", 1'b0, 1'b0);
        setup(2'b11, 7'b0000000, 6'd0, 1'b0, 1'b0, 1'b1); new_slot(); rx("R2 zero code rx", 1'b1, 1'b1, 1'b0);
        setup(2'b11, 7'b0000001, 6'd3, 1'b1, 1'b0, 1'b0); tx_slot("R3 slot mismatch tx", 1'b0, 1'b0);
        setup(2'b11, 7'b0000001, 6'd3, 1'b0, 1'b0, 1'b0); new_slot(); rx("R3 slot mismatch rx", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_single_chan();
        setup(2'b10, 7'b0000001, 6'd4, 1'b1, 1'b0, 1'b1); tx_slot("R4 tx A only", 1'b1, 1'b0);
        setup(2'b10, 7'b0000001, 6'd4, 1'b0, 1'b0, 1'b1); new_slot();
        rx("R4 rx on B dropped", 1'b0, 1'b1, 1'b0);
        rx("R4 rx on A stored", 1'b1, 1'b0, 1'b1);
        setup(2'b01, 7'b0000001, 6'd4, 1'b1, 1'b1, 1'b1); tx_slot("R5 tx B only", 1'b0, 1'b1);
        setup(2'b01, 7'b0000001, 6'd4, 1'b0, 1'b0, 1'b1); new_slot();
        rx("R5 rx on A dropped", 1'b1, 1'b0, 1'b0);
        rx("R5 rx on B stored", 1'b0, 1'b1, 1'b1);
        setup(2'b00, 7'b0000001, 6'd4, 1'b1, 1'b0, 1'b1); tx_slot("R6 no tx", 1'b0, 1'b0);
        setup(2'b00, 7'b0000001, 6'd4, 1'b0, 1'b0, 1'b1); new_slot();
        rx("R6 rx dropped", 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_dual_chan();
        setup(2'b11, 7'b0000001, 6'd7, 1'b1, 1'b0, 1'b1); tx_slot("R7 static tx both", 1'b1, 1'b1);
        setup(2'b11, 7'b0000001, 6'd7, 1'b0, 1'b0, 1'b1); new_slot();
        rx("R7 first frame on B stored", 1'b0, 1'b1, 1'b1);
        rx("R9 second frame on A dropped", 1'b1, 1'b0, 1'b0);
        new_slot();
        rx("R9 re-armed after slot start", 1'b1, 1'b0, 1'b1);
        new_slot();
        rx("R9 simultaneous A and B one pulse", 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        check("R9 no second pulse", {tx_en_a, tx_en_b, store}, 3'b000);
        // strobe in the slot_start cycle belongs to the new slot
        slot_start = 1'b1; rx_valid_a = 1'b1;
        @(negedge clk);
        slot_start = 1'b0; rx_valid_a = 1'b0;
        check("R9 strobe with slot start stored", {tx_en_a, tx_en_b, store}, 3'b001);
        setup(2'b11, 7'b0000001, 6'd7, 1'b1, 1'b1, 1'b1); tx_slot("R8 dynamic dual no tx", 1'b0, 1'b0);
        setup(2'b11, 7'b0000001, 6'd7, 1'b0, 1'b1, 1'b1); new_slot();
        rx("R8 dynamic dual rx dropped", 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_direction();
        setup(2'b11, 7'b0000001, 6'd1, 1'b0, 1'b0, 1'b1); tx_slot("R11 rx buffer never sends", 1'b0, 1'b0);
        setup(2'b11, 7'b0000001, 6'd1, 1'b1, 1'b0, 1'b1);
        rx("R11 tx buffer never stores", 1'b1, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        slot_start = 1'b0; rx_valid_a = 1'b0; rx_valid_b = 1'b0;
        setup(2'b00, 7'b0, 6'd0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_cycle_code();
        t_zero_and_slot();
        t_single_chan();
        t_dual_chan();
        t_direction();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule